// File: doc/BRIEF.md
# Command Response Halfword Buffer

This block sits behind the command line of an SD/MMC host port. After a command has gone out, it watches the incoming command line and waits for the start bit of the card's answer. It then shifts the response in, one bit for each sample strobe, into a left-aligned buffer. Software reads the buffered answer as a run of 16-bit halfwords from a single register address. Each read returns the next halfword, most significant first, so 32-bit words are rebuilt with shifts.

A 3-bit response-format code is taken when a command starts. It selects a short 48-bit answer, read as three halfwords, or a long 136-bit answer, read as nine halfwords. Any other code means the command expects no answer at all. When the last bit of the answer has been captured, a level status bit goes high and stays high. An event pulse marks the same moment for one cycle. The status bit stays high until the next command starts.

Top module: `rsp_halfword_fifo`

## Requirements
- R1: After reset, `done_status`, `done_pulse` and `rd_data` are 0, and every read returns 0 until a command with a response has been captured.
- R2: `cfg_fmt` is taken only in the cycle where `cmd_start` is high. Codes 1 and 3 select a 48-bit answer read as 3 halfwords. Code 2 selects a 136-bit answer read as 9 halfwords. Changes to `cfg_fmt` at any other time have no effect.
- R3: With code 0 or codes 4 to 7, nothing is captured. `done_status` and `done_pulse` are both high in the cycle after `cmd_start`, and every read returns 0.
- R4: Once armed, capture starts at the first sample in which `cmd_line` is 0. Earlier samples in which `cmd_line` is 1 are discarded. That 0 start bit becomes the most significant bit of the frame.
- R5: A bit is taken only in a cycle where `sample_en` is high. `cmd_line` is ignored in every other cycle.
- R6: For a short answer, three reads return frame bits [47:32], [31:16] and [15:0] in that order. `rd_data` changes in the cycle after `rd_en` is high and holds its value until the next read or the next `cmd_start`.
- R7: A long answer is held left-aligned in 144 bits. Nine reads return it most significant halfword first, and the low 8 bits of the ninth read are 0.
- R8: A read after the last valid halfword returns 0. The read position does not wrap, so further reads keep returning 0.
- R9: `done_status` and `done_pulse` rise in the cycle after the edge that takes the final frame bit. `done_pulse` lasts one cycle. `done_status` stays high until the next `cmd_start` and is not high before the final bit.
- R10: `cmd_start` clears the buffer, `done_status`, `rd_data` and the read position. It takes priority over a `rd_en` or a `sample_en` in the same cycle, and it abandons any capture that is still in progress.
- R11: Samples that arrive after a capture has completed do not change the buffered answer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | A new command has been sent: clears the block and arms capture |
| cfg_fmt | input | 3 | Response-format code, taken with `cmd_start` |
| sample_en | input | 1 | Strobe: take `cmd_line` this cycle |
| cmd_line | input | 1 | Command-line bit from the card |
| rd_en | input | 1 | Read of the response address |
| rd_data | output | HW_BITS | Halfword returned by the most recent read |
| done_status | output | 1 | Level: the answer is complete |
| done_pulse | output | 1 | One-cycle event when the answer completes |

## Verification
The assertions assume that `cmd_start`, `rd_en` and `sample_en` are clean single-cycle-or-longer levels with no X after reset. They also assume that a format code with a response is never followed by a second `done_pulse` unless a new `cmd_start` comes first. The bench drives every input on the falling clock edge, so each one is a settled level at the rising edge. It uses `cmd_start` only between frames, except in the directed cases that abort a frame or collide with a read. The random part mixes idle gaps that carry random `cmd_line` values, leading idle-high samples before the start bit, stray samples after completion and `cfg_fmt` changes during capture. None of these may alter the result.

// File: rtl/rsp_fifo_pkg.sv
package rsp_fifo_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_ARMED,
        CAP_SHIFT,
        CAP_DONE
    } cap_state_e;

    typedef enum logic [1:0] {
        RSP_NONE,
        RSP_SHORT,
        RSP_LONG
    } rsp_kind_e;

    // format codes; the numeric values are part of the command-setup field
    localparam logic [2:0] FMT_NONE    = 3'd0;
    localparam logic [2:0] FMT_SHORT_A = 3'd1;
    localparam logic [2:0] FMT_LONG    = 3'd2;
    localparam logic [2:0] FMT_SHORT_B = 3'd3;

endpackage

// File: rtl/rsp_fmt_decode.sv
module rsp_fmt_decode
    import rsp_fifo_pkg::*;
#(
    parameter int SHORT_BITS = 48,
    parameter int LONG_BITS  = 136,
    parameter int HW_BITS    = 16,
    parameter int CNT_W      = 8,
    parameter int PTR_W      = 4
) (
    input  logic [2:0]       fmt,
    output rsp_kind_e        kind,
    output logic [CNT_W-1:0] frame_len,
    output logic [PTR_W-1:0] n_half
);
    localparam int SHORT_HW = (SHORT_BITS + HW_BITS - 1) / HW_BITS;
    localparam int LONG_HW  = (LONG_BITS + HW_BITS - 1) / HW_BITS;

    always_comb begin
        kind      = RSP_NONE;
        frame_len = '0;
        n_half    = '0;
        unique case (fmt)
            FMT_SHORT_A, FMT_SHORT_B: begin
                kind      = RSP_SHORT;
                frame_len = CNT_W'(SHORT_BITS);
                n_half    = PTR_W'(SHORT_HW);
            end
            FMT_LONG: begin
                kind      = RSP_LONG;
                frame_len = CNT_W'(LONG_BITS);
                n_half    = PTR_W'(LONG_HW);
            end
            default: begin
                kind      = RSP_NONE;
                frame_len = '0;
                n_half    = '0;
            end
        endcase
    end

endmodule

// File: rtl/rsp_capture.sv
module rsp_capture
    import rsp_fifo_pkg::*;
#(
    parameter int BUF_W = 144,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             has_rsp,
    input  logic [CNT_W-1:0] frame_len,
    input  logic             sample_en,
    input  logic             cmd_line,
    output logic [BUF_W-1:0] buf_o,
    output logic             done_status,
    output logic             done_pulse
);
    localparam int IDX_W = $clog2(BUF_W);

    typedef struct packed {
        cap_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic [BUF_W-1:0] shreg;
        logic             done;
        logic             pulse;
    } cap_t;

    cap_t cap_d, cap_q;
    logic             take_bit;
    logic [IDX_W-1:0] wr_idx;

    always_comb begin
        cap_d       = cap_q;
        cap_d.pulse = 1'b0;
        wr_idx      = IDX_W'(BUF_W - 1) - IDX_W'(cap_q.cnt);
        take_bit    = sample_en &&
                      ((cap_q.state == CAP_SHIFT) ||
                       ((cap_q.state == CAP_ARMED) && !cmd_line));

        if (cmd_start) begin
            cap_d.shreg = '0;
            cap_d.cnt   = '0;
            cap_d.len   = frame_len;
            if (has_rsp) begin
                cap_d.state = CAP_ARMED;
                cap_d.done  = 1'b0;
            end else begin
                cap_d.state = CAP_DONE;
                cap_d.done  = 1'b1;
                cap_d.pulse = 1'b1;
            end
        end else if (take_bit) begin
            // bits fill from the top of the buffer downward
            cap_d.shreg[wr_idx] = cmd_line;
            cap_d.cnt           = cap_q.cnt + 1'b1;
            cap_d.state         = CAP_SHIFT;
            if ((cap_q.cnt + 1'b1) == cap_q.len) begin
                cap_d.state = CAP_DONE;
                cap_d.done  = 1'b1;
                cap_d.pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '{state: CAP_IDLE, cnt: '0, len: '0, shreg: '0,
                       done: 1'b0, pulse: 1'b0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign buf_o       = cap_q.shreg;
    assign done_status = cap_q.done;
    assign done_pulse  = cap_q.pulse;

endmodule

// File: rtl/rsp_read_seq.sv
module rsp_read_seq #(
    parameter int BUF_W   = 144,
    parameter int HW_BITS = 16,
    parameter int NHW     = 9,
    parameter int PTR_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic [PTR_W-1:0]   n_half,
    input  logic               rd_en,
    input  logic [BUF_W-1:0]   buf_i,
    output logic [HW_BITS-1:0] rd_data,
    output logic [PTR_W-1:0]   ptr_o,
    output logic [PTR_W-1:0]   lim_o
);
    localparam int HW_IDX_W = (NHW > 1) ? $clog2(NHW) : 1;

    typedef struct packed {
        logic [PTR_W-1:0]   ptr;
        logic [PTR_W-1:0]   lim;
        logic [HW_BITS-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [HW_BITS-1:0] hw [NHW];

    for (genvar k = 0; k < NHW; k++) begin : g_hw
        assign hw[k] = buf_i[BUF_W-1-HW_BITS*k -: HW_BITS];
    end

    always_comb begin
        rd_d = rd_q;
        if (cmd_start) begin
            rd_d.ptr  = '0;
            rd_d.lim  = n_half;
            rd_d.data = '0;
        end else if (rd_en) begin
            if (rd_q.ptr < rd_q.lim) begin
                rd_d.data = hw[rd_q.ptr[HW_IDX_W-1:0]];
                rd_d.ptr  = rd_q.ptr + 1'b1;
            end else begin
                rd_d.data = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '{ptr: '0, lim: '0, data: '0};
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q.data;
    assign ptr_o   = rd_q.ptr;
    assign lim_o   = rd_q.lim;

endmodule

// File: rtl/rsp_halfword_fifo.sv
module rsp_halfword_fifo
    import rsp_fifo_pkg::*;
#(
    parameter int SHORT_BITS = 48,
    parameter int LONG_BITS  = 136,
    parameter int HW_BITS    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic [2:0]         cfg_fmt,
    input  logic               sample_en,
    input  logic               cmd_line,
    input  logic               rd_en,
    output logic [HW_BITS-1:0] rd_data,
    output logic               done_status,
    output logic               done_pulse
);
    localparam int NHW   = (LONG_BITS + HW_BITS - 1) / HW_BITS;
    localparam int BUF_W = NHW * HW_BITS;
    localparam int CNT_W = $clog2(LONG_BITS + 1);
    localparam int PTR_W = $clog2(NHW + 1);

    rsp_kind_e        dec_kind;
    logic             dec_has_rsp;
    logic [CNT_W-1:0] dec_len;
    logic [PTR_W-1:0] dec_nhalf;
    logic [BUF_W-1:0] cap_buf;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] rd_lim;

    rsp_fmt_decode #(
        .SHORT_BITS (SHORT_BITS),
        .LONG_BITS  (LONG_BITS),
        .HW_BITS    (HW_BITS),
        .CNT_W      (CNT_W),
        .PTR_W      (PTR_W)
    ) u_dec (
        .fmt       (cfg_fmt),
        .kind      (dec_kind),
        .frame_len (dec_len),
        .n_half    (dec_nhalf)
    );

    assign dec_has_rsp = (dec_kind != RSP_NONE);

    rsp_capture #(
        .BUF_W (BUF_W),
        .CNT_W (CNT_W)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .has_rsp     (dec_has_rsp),
        .frame_len   (dec_len),
        .sample_en   (sample_en),
        .cmd_line    (cmd_line),
        .buf_o       (cap_buf),
        .done_status (done_status),
        .done_pulse  (done_pulse)
    );

    rsp_read_seq #(
        .BUF_W   (BUF_W),
        .HW_BITS (HW_BITS),
        .NHW     (NHW),
        .PTR_W   (PTR_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .n_half    (dec_nhalf),
        .rd_en     (rd_en),
        .buf_i     (cap_buf),
        .rd_data   (rd_data),
        .ptr_o     (rd_ptr),
        .lim_o     (rd_lim)
    );

endmodule

// File: rtl/rsp_fifo_chk.sv
module rsp_fifo_chk #(
    parameter int HW_BITS = 16,
    parameter int PTR_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_start,
    input logic               has_rsp,
    input logic               rd_en,
    input logic [HW_BITS-1:0] rd_data,
    input logic [PTR_W-1:0]   rd_ptr,
    input logic [PTR_W-1:0]   rd_lim,
    input logic               done_status,
    input logic               done_pulse
);

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse && !cmd_start |=> !done_pulse);

    // R9
    pulse_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> done_status);

    // R9
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_status && !cmd_start |=> done_status);

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start && has_rsp |=> !done_status && (rd_data == '0) && (rd_ptr == '0));

    // R3
    none_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start && !has_rsp |=> done_status && done_pulse);

    // R8
    overread_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !cmd_start && (rd_ptr >= rd_lim) |=> (rd_data == '0) && $stable(rd_ptr));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en && !cmd_start |=> $stable(rd_data));

    // R8
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= rd_lim);

endmodule

bind rsp_halfword_fifo rsp_fifo_chk #(
    .HW_BITS (HW_BITS),
    .PTR_W   (PTR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .has_rsp     (dec_has_rsp),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .rd_ptr      (rd_ptr),
    .rd_lim      (rd_lim),
    .done_status (done_status),
    .done_pulse  (done_pulse)
);

// File: tb/rsp_halfword_fifo_bench.sv
module rsp_halfword_fifo_bench;

    localparam int TOP = 144;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [2:0]  cfg_fmt = 3'd0;
    logic        sample_en = 1'b0;
    logic        cmd_line = 1'b1;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        done_status;
    logic        done_pulse;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int unsigned seed_val;

    always #5 clk = ~clk;

    rsp_halfword_fifo u_rsp_halfword_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .cfg_fmt     (cfg_fmt),
        .sample_en   (sample_en),
        .cmd_line    (cmd_line),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .done_status (done_status),
        .done_pulse  (done_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int frame_bits(input logic [2:0] f);
        if (f == 3'd1 || f == 3'd3) return 48;
        if (f == 3'd2) return 136;
        return 0;
    endfunction

    function automatic int frame_halves(input logic [2:0] f);
        return (frame_bits(f) + 15) / 16;
    endfunction

    function automatic logic [TOP-1:0] make_frame(input int len);
        logic [TOP-1:0] v = '0;
        for (int i = 1; i < len; i++) v[TOP-1-i] = 1'($urandom % 2);
        return v;
    endfunction

    task automatic start_cmd(input logic [2:0] f);
        @(negedge clk);
        cmd_start = 1'b1;
        cfg_fmt   = f;
        @(negedge clk);
        cmd_start = 1'b0;
        if (frame_bits(f) == 0) begin
            check(done_status && done_pulse, "R3 done after no-response start",
                  {30'd0, done_status, done_pulse}, 32'h3);
        end else begin
            check(!done_status && rd_data == 16'h0, "R10 start clears",
                  {15'd0, done_status, rd_data}, 32'h0);
        end
    endtask

    task automatic rd_one(output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic send_frame(input logic [TOP-1:0] fr, input int len);
        bit early = 1'b0;
        int lead = $urandom % 4;
        for (int i = 0; i < lead; i++) begin
            @(negedge clk);
            sample_en = 1'b1;
            cmd_line  = 1'b1;   // idle-high before the start bit (R4)
        end
        for (int i = 0; i < len; i++) begin
            int gap = $urandom % 3;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                sample_en = 1'b0;
                cmd_line  = 1'($urandom % 2);   // R5 ignored without strobe
                cfg_fmt   = 3'($urandom);       // R2 ignored outside start
            end
            @(negedge clk);
            if (done_status) early = 1'b1;
            sample_en = 1'b1;
            cmd_line  = fr[TOP-1-i];
        end
        @(negedge clk);
        sample_en = 1'b0;
        cmd_line  = 1'b1;
        check(!early, "R9 status not early", {31'd0, early}, 32'd0);
        check(done_status && done_pulse, "R9 done after last bit",
              {30'd0, done_status, done_pulse}, 32'h3);
        @(negedge clk);
        check(done_status && !done_pulse, "R9 pulse one cycle, status held",
              {30'd0, done_status, done_pulse}, 32'h2);
    endtask

    task automatic read_all(input logic [TOP-1:0] fr, input int n, input string req);
        logic [15:0] v;
        for (int k = 0; k < n; k++) begin
            rd_one(v);
            check(v == fr[TOP-1-16*k -: 16], req, {16'd0, v}, {16'd0, fr[TOP-1-16*k -: 16]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [TOP-1:0] fr;
        logic [15:0]    v;
        logic [2:0]     f;
        seed_val = $urandom(32'h5eed_1234);

        repeat (3) @(negedge clk);
        // R1 reset state
        check(!done_status && !done_pulse && rd_data == 16'h0, "R1 reset outputs",
              {14'd0, done_status, done_pulse, rd_data}, 32'h0);
        rst_n = 1'b1;
        rd_one(v);
        check(v == 16'h0, "R1 read before any capture", {16'd0, v}, 32'h0);

        // R3 no-response codes
        foreach (f_list[i]) begin
            start_cmd(f_list[i]);
            @(negedge clk);
            check(done_status && !done_pulse, "R3 pulse single", {30'd0, done_status, done_pulse}, 32'h2);
            rd_one(v);
            check(v == 16'h0, "R3 read returns zero", {16'd0, v}, 32'h0);
        end

        // R6 directed short frame, code 1
        fr = '0;
        fr[TOP-1 -: 48] = 48'h3F12_A5C3_9E01;
        start_cmd(3'd1);
        send_frame(fr, 48);
        rd_one(v);
        check(v == 16'h3F12, "R6 first halfword is bits 47:32", {16'd0, v}, 32'h3F12);
        repeat (3) @(negedge clk);
        check(rd_data == 16'h3F12, "R6 rd_data held without read", {16'd0, rd_data}, 32'h3F12);
        rd_one(v);
        check(v == 16'hA5C3, "R6 second halfword", {16'd0, v}, 32'hA5C3);
        rd_one(v);
        check(v == 16'h9E01, "R6 third halfword", {16'd0, v}, 32'h9E01);
        for (int k = 0; k < 3; k++) begin
            rd_one(v);
            check(v == 16'h0, "R8 overread zero, no wrap", {16'd0, v}, 32'h0);
        end

        // R7 directed long frame
        fr = make_frame(136);
        start_cmd(3'd2);
        send_frame(fr, 136);
        read_all(fr, 9, "R7 long halfword");
        check(fr[7:0] == 8'h0, "R7 low byte padding", {24'd0, fr[7:0]}, 32'h0);
        rd_one(v);
        check(v == 16'h0, "R8 read after ninth", {16'd0, v}, 32'h0);

        // random mix: R2 R4 R5 R11
        for (int t = 0; t < 30; t++) begin
            int sel = $urandom % 3;
            f = (sel == 0) ? 3'd1 : (sel == 1) ? 3'd3 : 3'd2;
            fr = make_frame(frame_bits(f));
            start_cmd(f);
            send_frame(fr, frame_bits(f));
            if ($urandom % 2 == 1) begin
                for (int s = 0; s < 5; s++) begin
                    @(negedge clk);
                    sample_en = 1'b1;
                    cmd_line  = 1'($urandom % 2);   // R11 stray samples
                end
                @(negedge clk);
                sample_en = 1'b0;
                read_all(fr, frame_halves(f), "R11 stray samples ignored");
            end else begin
                read_all(fr, frame_halves(f), "R2 format selects length");
            end
            rd_one(v);
            check(v == 16'h0, "R8 overread random", {16'd0, v}, 32'h0);
        end

        // R10 abort mid-frame, then restart with long
        start_cmd(3'd1);
        fr = make_frame(48);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            sample_en = 1'b1;
            cmd_line  = fr[TOP-1-i];
        end
        @(negedge clk);
        sample_en = 1'b0;
        fr = make_frame(136);
        start_cmd(3'd2);
        send_frame(fr, 136);
        read_all(fr, 9, "R10 restart after abort");

        // R10 start collides with a read
        fr = make_frame(48);
        start_cmd(3'd3);
        send_frame(fr, 48);
        rd_one(v);
        @(negedge clk);
        cmd_start = 1'b1;
        rd_en     = 1'b1;
        sample_en = 1'b1;
        cmd_line  = 1'b0;
        cfg_fmt   = 3'd3;
        @(negedge clk);
        cmd_start = 1'b0;
        rd_en     = 1'b0;
        sample_en = 1'b0;
        cmd_line  = 1'b1;
        check(rd_data == 16'h0 && !done_status, "R10 start wins over read",
              {15'd0, done_status, rd_data}, 32'h0);
        fr = make_frame(48);
        send_frame(fr, 48);
        read_all(fr, 3, "R10 read position reset");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [2:0] f_list [5] = '{3'd0, 3'd4, 3'd5, 3'd6, 3'd7};

endmodule